// File: doc/BRIEF.md
# Level-Sensitive Eight-Line Priority Interrupt Controller

This block gathers eight device request lines and presents one interrupt to a processor. Every request is taken as a level: the controller never latches an edge, so a device that keeps its line high after its service has been closed is offered again on the very next cycle. The processor talks to the block through two write targets, a command port and a mask port, and it can read the mask back at any time so that it can read, modify and write it.

Each cycle the controller forms the set of eligible requests. A request is eligible when its line is high, its mask bit is clear, and no line of equal or higher priority is in service. Line 0 has the highest priority and line 7 the lowest. The interrupt output is high whenever that set is non-empty. An acknowledge pulse returns a vector, the configured base plus the winning line number, and marks that line as in service at the next clock edge. Software closes a service with an end-of-interrupt command. A non-specific command closes the highest-priority active service. A specific command names a single line.

Setup commands may only select level operation. A setup byte that asks for edge operation is dropped without any effect, so the block cannot leave level mode.

Top module: `lvl_pic`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, the mask reads 0x00, no line is in service, and `irq_o` is low when all requests are low.
- R2: `irq_o` is high in any cycle where at least one eligible request exists. Eligible means the line is high, it is unmasked, and no line of equal or smaller index is in service. A line still high after its service is closed raises `irq_o` again in the cycle after the closing command.
- R3: While `ack_i` is high, `vector_o` equals `VEC_BASE` plus the index of the smallest-numbered eligible line, so line 0 wins over all others. While `ack_i` is low, `vector_o` is 0x00.
- R4: A write to the mask port (`wr_sel` = 1) loads the written byte at the next edge, and `mask_o` then reads it back. Bit n set suppresses line n. Clearing the bit lets a line that is still high interrupt again, with no new edge needed.
- R5: An acknowledge that finds an eligible line sets that line's in-service bit at the next edge. From then on, that line and every higher-numbered line are blocked, and lower-numbered lines can still interrupt.
- R6: Command byte 0x20 (non-specific end of interrupt) clears the in-service bit with the smallest index. It does nothing when no line is in service.
- R7: Command bytes 0x60 to 0x67 (specific end of interrupt) clear only the in-service bit of line `byte[2:0]`, and leave all other lines unchanged.
- R8: A command byte whose upper nibble is 0x1 is a setup command. When bit 3 is 1 (level), it clears every in-service bit and the whole mask. When bit 3 is 0 (edge), it is ignored: mask and in-service state stay unchanged.
- R9: Any other command byte (for example 0x00, 0x2F, 0x40, 0xA5) leaves mask and in-service state unchanged.
- R10: An acknowledge with no eligible line returns `VEC_BASE` + 7 and changes no in-service bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 8 | Device request levels, bit n for line n |
| wr_en | input | 1 | Host write strobe, one cycle |
| wr_sel | input | 1 | Write target: 0 = command port, 1 = mask port |
| wr_data | input | 8 | Host write byte |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| irq_o | output | 1 | Interrupt request to the processor |
| vector_o | output | 8 | Vector returned during acknowledge, otherwise 0x00 |
| mask_o | output | 8 | Current mask register, for read-back |

## Verification
Some behaviours are checked by the assertions on every cycle. These are: `irq_o` never rises without an unmasked high request, the vector stays inside the window of eight, a granted acknowledge adds exactly one in-service bit, a specific end of interrupt leaves its named line clear, an edge setup leaves both registers stable, and a mask write lands as written. The priority order, the blocking of equal and lower priorities, and the immediate re-presentation of a held line after its service is closed depend on a sequence of acknowledges and commands. Only the bench's scenarios, checked against its cycle model, can show those.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int NLINES = 8;
    localparam int IDX_W  = $clog2(NLINES);

    localparam logic [7:0] CMD_NS_EOI    = 8'h20;
    localparam logic [4:0] CMD_SP_EOI_HI = 5'b01100;
    localparam logic [3:0] CMD_SETUP_HI  = 4'b0001;
    localparam int         SETUP_LVL_BIT = 3;

    typedef enum logic [2:0] {
        K_NONE,
        K_NS_EOI,
        K_SP_EOI,
        K_SETUP_LVL,
        K_SETUP_EDGE
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e          kind;
        logic [IDX_W-1:0]   line;
    } cmd_t;

    typedef struct packed {
        logic               found;
        logic [IDX_W-1:0]   idx;
    } pick_t;

    function automatic cmd_t decode_cmd(input logic [7:0] b);
        cmd_t c;
        c.kind = K_NONE;
        c.line = b[IDX_W-1:0];
        if (b[7:4] == CMD_SETUP_HI) begin
            c.kind = b[SETUP_LVL_BIT] ? K_SETUP_LVL : K_SETUP_EDGE;
        end else if (b == CMD_NS_EOI) begin
            c.kind = K_NS_EOI;
        end else if (b[7:3] == CMD_SP_EOI_HI) begin
            c.kind = K_SP_EOI;
        end
        return c;
    endfunction

    function automatic pick_t lowest_set(input logic [NLINES-1:0] v);
        pick_t p;
        p.found = 1'b0;
        p.idx   = '0;
        for (int i = NLINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.found = 1'b1;
                p.idx   = IDX_W'(i);
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
    import pic_pkg::*;
(
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [7:0]  wr_data,
    output cmd_t        cmd,
    output logic        cmd_valid,
    output logic        mask_wr
);
    always_comb begin
        cmd       = decode_cmd(wr_data);
        cmd_valid = wr_en && !wr_sel;
        mask_wr   = wr_en && wr_sel;
    end
endmodule

// File: rtl/pic_prio_resolve.sv
module pic_prio_resolve
    import pic_pkg::*;
(
    input  logic [NLINES-1:0] req,
    input  logic [NLINES-1:0] mask,
    input  logic [NLINES-1:0] isr,
    output logic [NLINES-1:0] eligible,
    output logic              any,
    output logic [IDX_W-1:0]  win_idx
);
    logic [NLINES-1:0] allowed;
    pick_t             pick;

    genvar g;
    generate
        for (g = 0; g < NLINES; g++) begin : g_allow
            assign allowed[g] = ~|isr[g:0];
        end
    endgenerate

    always_comb begin
        eligible = req & ~mask & allowed;
        pick     = lowest_set(eligible);
        any      = pick.found;
        win_idx  = pick.idx;
    end
endmodule

// File: rtl/pic_state_regs.sv
module pic_state_regs
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    input  logic              cmd_valid,
    input  logic              mask_wr,
    input  logic [7:0]        wr_data,
    input  logic [NLINES-1:0] isr_set,
    output logic [NLINES-1:0] isr,
    output logic [NLINES-1:0] mask
);
    logic [NLINES-1:0] isr_clr;
    logic [NLINES-1:0] isr_n;
    logic [NLINES-1:0] mask_n;
    pick_t             top_svc;

    always_comb begin
        top_svc = lowest_set(isr);
        isr_clr = '0;
        if (cmd_valid) begin
            unique case (cmd.kind)
                K_NS_EOI: if (top_svc.found) isr_clr[top_svc.idx] = 1'b1;
                K_SP_EOI: isr_clr[cmd.line] = 1'b1;
                default:  ;
            endcase
        end
        isr_n  = (isr & ~isr_clr) | isr_set;
        mask_n = mask;
        if (mask_wr) mask_n = wr_data[NLINES-1:0];
        if (cmd_valid && cmd.kind == K_SETUP_LVL) begin
            isr_n  = '0;
            mask_n = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr  <= '0;
            mask <= '0;
        end else begin
            isr  <= isr_n;
            mask <= mask_n;
        end
    end

    a_r7_specific_clears_line: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd.kind == K_SP_EOI && isr_set == '0)
        |=> !isr[$past(cmd.line)]);

    a_r8_edge_setup_ignored: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd.kind == K_SETUP_EDGE && isr_set == '0)
        |=> ($stable(isr) && $stable(mask)));

    a_r4_mask_write_lands: assert property (@(posedge clk) disable iff (rst)
        mask_wr |=> (mask == $past(wr_data[NLINES-1:0])));

    a_r6_nseoi_drops_one: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd.kind == K_NS_EOI && isr_set == '0 && isr != '0)
        |=> ($countones(isr) + 1 == $countones($past(isr))));
endmodule

// File: rtl/lvl_pic.sv
module lvl_pic
    import pic_pkg::*;
#(
    parameter logic [7:0] VEC_BASE = 8'h08
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  req_i,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [7:0]  wr_data,
    input  logic        ack_i,
    output logic        irq_o,
    output logic [7:0]  vector_o,
    output logic [7:0]  mask_o
);
    localparam logic [IDX_W-1:0] SPURIOUS_IDX = IDX_W'(NLINES - 1);

    cmd_t              cmd;
    logic              cmd_valid;
    logic              mask_wr;
    logic [NLINES-1:0] isr;
    logic [NLINES-1:0] mask;
    logic [NLINES-1:0] eligible;
    logic              any;
    logic [IDX_W-1:0]  win_idx;
    logic [NLINES-1:0] isr_set;
    logic [IDX_W-1:0]  vec_idx;

    pic_cmd_decode u_dec (
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .cmd       (cmd),
        .cmd_valid (cmd_valid),
        .mask_wr   (mask_wr)
    );

    pic_prio_resolve u_prio (
        .req      (req_i),
        .mask     (mask),
        .isr      (isr),
        .eligible (eligible),
        .any      (any),
        .win_idx  (win_idx)
    );

    always_comb begin
        isr_set = '0;
        if (ack_i && any) isr_set[win_idx] = 1'b1;
        vec_idx  = any ? win_idx : SPURIOUS_IDX;
        vector_o = ack_i ? (VEC_BASE + {{(8-IDX_W){1'b0}}, vec_idx}) : 8'h00;
        irq_o    = any;
        mask_o   = mask;
    end

    pic_state_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .cmd_valid (cmd_valid),
        .mask_wr   (mask_wr),
        .wr_data   (wr_data),
        .isr_set   (isr_set),
        .isr       (isr),
        .mask      (mask)
    );

    a_r2_irq_has_source: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> |(req_i & ~mask_o));

    a_r3_vector_window: assert property (@(posedge clk) disable iff (rst)
        ack_i |-> (vector_o >= VEC_BASE && vector_o <= VEC_BASE + 8'd7));

    a_r5_ack_adds_one: assert property (@(posedge clk) disable iff (rst)
        (ack_i && irq_o && !wr_en)
        |=> ($countones(isr) == $countones($past(isr)) + 1));

    a_r10_spurious_keeps_isr: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !irq_o && !wr_en) |=> $stable(isr));
endmodule

// File: tb/lvl_pic_tb.sv
module lvl_pic_tb;
    localparam logic [7:0] BASE = 8'h08;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_i = '0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ack_i = 1'b0;
    logic       irq_o;
    logic [7:0] vector_o;
    logic [7:0] mask_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0] m_isr = '0;
    logic [7:0] m_mask = '0;

    always #4 clk = ~clk;

    lvl_pic #(.VEC_BASE(BASE)) u_dut (
        .clk(clk), .rst(rst), .req_i(req_i), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ack_i(ack_i), .irq_o(irq_o), .vector_o(vector_o),
        .mask_o(mask_o)
    );

    function automatic int model_winner(input logic [7:0] rq);
        for (int i = 0; i < 8; i++) begin
            bit blocked = 0;
            for (int j = 0; j <= i; j++) if (m_isr[j]) blocked = 1;
            if (rq[i] && !m_mask[i] && !blocked) return i;
        end
        return -1;
    endfunction

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic [7:0] rq, input bit we,
                        input bit sel, input logic [7:0] d, input bit ack);
        int w;
        int exp_vec;
        @(negedge clk);
        req_i = rq; wr_en = we; wr_sel = sel; wr_data = d; ack_i = ack;
        #1;
        w = model_winner(rq);
        exp_vec = ack ? ((w >= 0) ? BASE + w : BASE + 7) : 0;
        cmp(tag, "irq_o", int'(irq_o), (w >= 0) ? 1 : 0);
        cmp(tag, "vector_o", int'(vector_o), exp_vec);
        cmp(tag, "mask_o", int'(mask_o), int'(m_mask));
        @(posedge clk);
        if (we && !sel) begin
            if (d[7:4] == 4'h1) begin
                if (d[3]) begin m_isr = '0; m_mask = '0; end
            end else if (d == 8'h20) begin
                for (int i = 0; i < 8; i++) if (m_isr[i]) begin m_isr[i] = 1'b0; break; end
            end else if (d[7:3] == 5'b01100) begin
                m_isr[d[2:0]] = 1'b0;
            end
        end
        if (we && sel) m_mask = d;
        if (ack && w >= 0 && !(we && !sel && d[7:4] == 4'h1 && d[3])) m_isr[w] = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        step("R1", 8'h00, 0, 0, 8'h00, 0);
        step("R2", 8'h28, 0, 0, 8'h00, 0);
        step("R3", 8'h28, 0, 0, 8'h00, 1);
        step("R5", 8'h28, 0, 0, 8'h00, 0);
        step("R5", 8'h2A, 0, 0, 8'h00, 0);
        step("R3", 8'h2A, 0, 0, 8'h00, 1);
        step("R6", 8'h2A, 1, 0, 8'h20, 0);
        step("R2", 8'h2A, 0, 0, 8'h00, 0);
        step("R3", 8'h2A, 0, 0, 8'h00, 1);
        step("R7", 8'h28, 1, 0, 8'h63, 0);
        step("R7", 8'h28, 0, 0, 8'h00, 0);
        step("R7", 8'h28, 1, 0, 8'h65, 0);
        step("R7", 8'h28, 1, 0, 8'h61, 0);
        step("R7", 8'h28, 0, 0, 8'h00, 0);
        step("R4", 8'h28, 1, 1, 8'h08, 0);
        step("R4", 8'h28, 0, 0, 8'h00, 1);
        step("R4", 8'h28, 0, 0, 8'h00, 0);
        step("R4", 8'h28, 1, 1, 8'h80, 0);
        step("R4", 8'h28, 0, 0, 8'h00, 0);
        step("R8", 8'h28, 1, 0, 8'h13, 0);
        step("R8", 8'h28, 1, 0, 8'h10, 0);
        step("R8", 8'h28, 0, 0, 8'h00, 0);
        step("R9", 8'h28, 1, 0, 8'h00, 0);
        step("R9", 8'h28, 1, 0, 8'h2F, 0);
        step("R9", 8'h28, 1, 0, 8'h40, 0);
        step("R9", 8'h28, 1, 0, 8'hA5, 0);
        step("R9", 8'h28, 0, 0, 8'h00, 0);
        step("R8", 8'h28, 1, 0, 8'h1B, 0);
        step("R8", 8'h28, 0, 0, 8'h00, 0);
        step("R10", 8'h00, 0, 0, 8'h00, 1);
        step("R10", 8'h80, 0, 0, 8'h00, 0);
        step("R3", 8'hFF, 0, 0, 8'h00, 1);
        step("R5", 8'hFF, 0, 0, 8'h00, 0);
        step("R6", 8'hFF, 1, 0, 8'h20, 0);
        step("R6", 8'hFF, 0, 0, 8'h00, 0);
        for (int k = 0; k < 2000; k++) begin
            int r = $urandom_range(0, 9);
            logic [7:0] rq = 8'($urandom);
            case (r)
                0: step("R6", rq, 1, 0, 8'h20, 0);
                1: step("R7", rq, 1, 0, {5'b01100, 3'($urandom)}, 0);
                2: step("R4", rq, 1, 1, 8'($urandom) & 8'($urandom), 0);
                3: step("R8", rq, 1, 0, {4'h1, 1'b0, 3'($urandom)}, 0);
                4: step("R9", rq, 1, 0, 8'($urandom), 0);
                5, 6: step("R3", rq, 0, 0, 8'h00, 1);
                default: step("R2", rq, 0, 0, 8'h00, 0);
            endcase
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule